// File: doc/BRIEF.md
# Prioritized Task Queue Manager

This block keeps eight hardware task queues, each with its own bank of configuration registers, and feeds a single compute engine from them. Software sets up a queue bank with a priority, a status word, a node identifier and a table of base addresses. It then loads a descriptor address and an info word into the execution-port registers and writes a push word that names the queue and its priority. The push is captured into a per-queue pending slot. Nothing is sent to the engine at that point.

When the engine is free, the manager picks the pending queue with the highest priority, starts the engine with that queue's descriptor, and publishes the committed node identifier. An idle flag tells software whether a request is still running. The engine is represented by a start pulse with held descriptor outputs and a one-cycle completion input. Pushes that arrive while a request is running wait in their slots until the engine completes.

Top module: `task_queue_mgr`

## Requirements
- R1: After reset, status bit 0 (engine window offset 0x14) reads 1 and the commit word (offset 0x10) reads 0. The queue-enable word (offset 0x0C) reads 0x3000. The priority word of queue q reads 1, 2, 3, 4, 5, 6, 0x1E and 0x1F for q = 0 to 7.
- R2: The bank of queue q starts at address 0x1000 + q*0x148. Its status word is at bank offset 0x00, priority at 0x04, free-space at 0x08 and info at 0x0C. All four read back what was written, except that the info word keeps only bits 15:0.
- R3: The request-size word (bank offset 0x18) keeps only bits 24:16 of a write, so writing 0xFFFFFFFF reads back 0x01FF0000.
- R4: The node-id word (bank offset 0x10) keeps only bits 15:8 (node id) and bit 0 (valid), so writing 0xFFFFFFFF reads back 0x0000FF01.
- R5: Each bank has 32 base-address words starting at bank offset 0x40 with 4-byte spacing. Each word holds its own value, with no aliasing between queues or entries.
- R6: A write to the push word (offset 0x08) carries the priority in bits 7:0 and the queue id in bits 10:8. On dispatch, the engine outputs present that queue id, the descriptor address (offset 0x00) and the info word (offset 0x04) latched at push time: size from info bits 31:16 and count from bits 15:0.
- R7: A push made while the info word is zero is ignored. No dispatch follows and the status stays idle.
- R8: A push naming queue id 0 is ignored. Only ids 1 to 7 can be enqueued.
- R9: Among pending queues, the one with the highest pushed priority is dispatched first. On equal priority, the lower queue id goes first.
- R10: The start output is a one-cycle pulse issued only while idle. From the cycle after start until the cycle after the completion pulse, status bit 0 reads 0. Pushes made while busy are held and dispatched later.
- R11: On dispatch, the commit word bits 23:16 take the node id (bits 15:8 of the node-id word) of the dispatched queue.
- R12: A second push to a queue that is still pending replaces its earlier descriptor address and info word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 16 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| eng_start | output | 1 | One-cycle pulse that starts the engine |
| eng_qid | output | 3 | Queue id of the running request |
| eng_addr | output | 32 | Descriptor address of the running request |
| eng_td_size | output | 16 | Descriptor size of the running request |
| eng_td_count | output | 16 | Descriptor count of the running request |
| eng_done | input | 1 | Completion pulse from the engine |

## Verification
The hardest situation to reach is several queues pending at once with mixed and tied priorities. From idle, a single push is dispatched on the very next edge. The bench therefore first starts one request and holds off its completion. While that request runs, it pushes six more, including a tie and a replaced re-push. Each completion then releases exactly one dispatch, so the bench can compare the order, descriptors and committed node ids against a sequence it works out from the pushed priorities.

// File: rtl/tqm_pkg.sv
`timescale 1ns/1ps
package tqm_pkg;

    localparam int AW      = 16;
    localparam int DW      = 32;
    localparam int OFFW    = 9;

    localparam int QBASE   = 'h1000;
    localparam int QSTRIDE = 'h148;

    // engine window (absolute)
    localparam logic [AW-1:0] EA_ADDR   = 16'h0000;
    localparam logic [AW-1:0] EA_INFO   = 16'h0004;
    localparam logic [AW-1:0] EA_PUSH   = 16'h0008;
    localparam logic [AW-1:0] EA_QEN    = 16'h000C;
    localparam logic [AW-1:0] EA_COMMIT = 16'h0010;
    localparam logic [AW-1:0] EA_STAT   = 16'h0014;

    // per-queue bank offsets
    localparam logic [OFFW-1:0] QO_STAT = 9'h000;
    localparam logic [OFFW-1:0] QO_PRIO = 9'h004;
    localparam logic [OFFW-1:0] QO_FREE = 9'h008;
    localparam logic [OFFW-1:0] QO_INFO = 9'h00C;
    localparam logic [OFFW-1:0] QO_NID  = 9'h010;
    localparam logic [OFFW-1:0] QO_SIZE = 9'h018;
    localparam logic [OFFW-1:0] QO_BAR  = 9'h040;

    localparam logic [DW-1:0] SIZE_MASK = 32'h01FF_0000;
    localparam logic [DW-1:0] NID_MASK  = 32'h0000_FF01;
    localparam logic [DW-1:0] INFO_MASK = 32'h0000_FFFF;
    localparam logic [DW-1:0] QEN_RST   = 32'h0000_3000;

    typedef struct packed {
        logic [DW-1:0] addr;
        logic [DW-1:0] info;
        logic [7:0]    prio;
    } req_t;

    function automatic logic [7:0] dflt_prio(input int q);
        return (q < 6) ? 8'(q + 1) : 8'(q + 24);
    endfunction

endpackage

// File: rtl/tqm_qbank.sv
`timescale 1ns/1ps
module tqm_qbank
    import tqm_pkg::*;
#(
    parameter int         NUM_BAR  = 32,
    parameter logic [7:0] PRIO_RST = 8'd1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hit,
    input  logic [OFFW-1:0] off,
    input  logic            we,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic [7:0]      node_id
);
    localparam int BIW = (NUM_BAR > 1) ? $clog2(NUM_BAR) : 1;
    localparam logic [OFFW-1:0] BAR_END = OFFW'(int'(QO_BAR) + 4 * NUM_BAR);

    logic [DW-1:0] stat_r, prio_r, free_r, info_r, nid_r, size_r;
    logic [DW-1:0] bars [NUM_BAR];

    logic [OFFW-1:0] brel;
    logic            bar_hit;
    logic [BIW-1:0]  bar_idx;

    assign brel    = off - QO_BAR;
    assign bar_hit = hit && (off >= QO_BAR) && (off < BAR_END) && (off[1:0] == 2'b00);
    assign bar_idx = brel[BIW+1:2];
    assign node_id = nid_r[15:8];

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_r <= '0;
            prio_r <= DW'(PRIO_RST);
            free_r <= '0;
            info_r <= '0;
            nid_r  <= '0;
            size_r <= '0;
            for (int i = 0; i < NUM_BAR; i++) bars[i] <= '0;
        end else if (we && hit) begin
            case (off)
                QO_STAT: stat_r <= wdata;
                QO_PRIO: prio_r <= wdata;
                QO_FREE: free_r <= wdata;
                QO_INFO: info_r <= wdata & INFO_MASK;
                QO_NID:  nid_r  <= wdata & NID_MASK;
                QO_SIZE: size_r <= wdata & SIZE_MASK;
                default: ;
            endcase
            if (bar_hit) bars[bar_idx] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            case (off)
                QO_STAT: rdata = stat_r;
                QO_PRIO: rdata = prio_r;
                QO_FREE: rdata = free_r;
                QO_INFO: rdata = info_r;
                QO_NID:  rdata = nid_r;
                QO_SIZE: rdata = size_r;
                default: rdata = '0;
            endcase
            if (bar_hit) rdata = bars[bar_idx];
        end
    end

endmodule

// File: rtl/tqm_arb.sv
`timescale 1ns/1ps
module tqm_arb #(
    parameter int NUM_Q = 8,
    localparam int QW   = $clog2(NUM_Q)
) (
    input  logic [NUM_Q-1:0]      pend,
    input  logic [NUM_Q-1:0][7:0] prio,
    output logic                  any,
    output logic [QW-1:0]         sel
);
    logic [7:0] best;

    // ascending scan with strict compare: ties keep the lower id
    always_comb begin
        any  = 1'b0;
        sel  = '0;
        best = '0;
        for (int q = 0; q < NUM_Q; q++) begin
            if (pend[q] && (!any || (prio[q] > best))) begin
                any  = 1'b1;
                sel  = QW'(q);
                best = prio[q];
            end
        end
    end

endmodule

// File: rtl/tqm_disp.sv
`timescale 1ns/1ps
module tqm_disp
    import tqm_pkg::*;
#(
    parameter int NUM_Q = 8,
    localparam int QW   = $clog2(NUM_Q)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  push_fire,
    input  logic [QW-1:0]         push_q,
    input  req_t                  push_req,
    input  logic                  eng_done,
    input  logic [NUM_Q-1:0][7:0] node_id,
    output logic                  start,
    output logic [QW-1:0]         cur_q,
    output logic [DW-1:0]         cur_addr,
    output logic [DW-1:0]         cur_info,
    output logic [7:0]            commit_nid,
    output logic                  busy,
    output logic [NUM_Q-1:0]      pend,
    output logic [NUM_Q-1:0][7:0] slot_prio
);
    req_t             slot [NUM_Q];
    logic             any;
    logic [QW-1:0]    sel;
    logic             go;
    logic [NUM_Q-1:0] pend_n;

    for (genvar q = 0; q < NUM_Q; q++) begin : g_sp
        assign slot_prio[q] = slot[q].prio;
    end

    tqm_arb #(.NUM_Q(NUM_Q)) u_arb (
        .pend (pend),
        .prio (slot_prio),
        .any  (any),
        .sel  (sel)
    );

    assign go = !busy && any;

    always_comb begin
        pend_n = pend;
        if (go)        pend_n[sel]    = 1'b0;
        if (push_fire) pend_n[push_q] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend       <= '0;
            busy       <= 1'b0;
            start      <= 1'b0;
            cur_q      <= '0;
            cur_addr   <= '0;
            cur_info   <= '0;
            commit_nid <= '0;
            for (int q = 0; q < NUM_Q; q++) slot[q] <= '0;
        end else begin
            pend  <= pend_n;
            start <= go;
            if (push_fire) slot[push_q] <= push_req;
            if (go) begin
                busy       <= 1'b1;
                cur_q      <= sel;
                cur_addr   <= slot[sel].addr;
                cur_info   <= slot[sel].info;
                commit_nid <= node_id[sel];
            end else if (busy && eng_done) begin
                busy <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/task_queue_mgr.sv
`timescale 1ns/1ps
module task_queue_mgr
    import tqm_pkg::*;
#(
    parameter int NUM_Q   = 8,
    parameter int NUM_BAR = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [15:0]   cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    output logic          eng_start,
    output logic [2:0]    eng_qid,
    output logic [31:0]   eng_addr,
    output logic [15:0]   eng_td_size,
    output logic [15:0]   eng_td_count,
    input  logic          eng_done
);
    localparam int QW = $clog2(NUM_Q);

    logic [DW-1:0] exec_addr_r, exec_info_r, qen_r;

    logic [NUM_Q-1:0]          qhit;
    logic [DW-1:0]             qrd [NUM_Q];
    logic [NUM_Q-1:0][7:0]     nid;

    logic                      push_fire;
    logic [QW-1:0]             push_q;
    req_t                      push_req;

    logic                      busy_w;
    logic [NUM_Q-1:0]          pend_w;
    logic [NUM_Q-1:0][7:0]     sprio_w;
    logic [QW-1:0]             cur_q;
    logic [DW-1:0]             cur_info;
    logic [7:0]                commit_nid;

    // queue banks
    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        localparam logic [AW-1:0] QB = AW'(QBASE + q * QSTRIDE);
        logic [AW-1:0] rel;
        assign rel     = cfg_addr - QB;
        assign qhit[q] = (cfg_addr >= QB) && (rel < AW'(QSTRIDE));

        tqm_qbank #(
            .NUM_BAR  (NUM_BAR),
            .PRIO_RST (dflt_prio(q))
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .hit     (qhit[q]),
            .off     (rel[OFFW-1:0]),
            .we      (cfg_we),
            .wdata   (cfg_wdata),
            .rdata   (qrd[q]),
            .node_id (nid[q])
        );
    end

    // execution-port registers
    always_ff @(posedge clk) begin
        if (rst) begin
            exec_addr_r <= '0;
            exec_info_r <= '0;
            qen_r       <= QEN_RST;
        end else if (cfg_we) begin
            if (cfg_addr == EA_ADDR) exec_addr_r <= cfg_wdata;
            if (cfg_addr == EA_INFO) exec_info_r <= cfg_wdata;
            if (cfg_addr == EA_QEN)  qen_r       <= cfg_wdata;
        end
    end

    assign push_q        = cfg_wdata[8 +: QW];
    assign push_fire     = cfg_we && (cfg_addr == EA_PUSH) &&
                           (exec_info_r != '0) && (push_q != '0);
    assign push_req.addr = exec_addr_r;
    assign push_req.info = exec_info_r;
    assign push_req.prio = cfg_wdata[7:0];

    tqm_disp #(.NUM_Q(NUM_Q)) u_disp (
        .clk        (clk),
        .rst        (rst),
        .push_fire  (push_fire),
        .push_q     (push_q),
        .push_req   (push_req),
        .eng_done   (eng_done),
        .node_id    (nid),
        .start      (eng_start),
        .cur_q      (cur_q),
        .cur_addr   (eng_addr),
        .cur_info   (cur_info),
        .commit_nid (commit_nid),
        .busy       (busy_w),
        .pend       (pend_w),
        .slot_prio  (sprio_w)
    );

    assign eng_qid      = 3'(cur_q);
    assign eng_td_size  = cur_info[31:16];
    assign eng_td_count = cur_info[15:0];

    // read mux
    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == EA_ADDR)   cfg_rdata = exec_addr_r;
        if (cfg_addr == EA_INFO)   cfg_rdata = exec_info_r;
        if (cfg_addr == EA_QEN)    cfg_rdata = qen_r;
        if (cfg_addr == EA_COMMIT) cfg_rdata = {8'h00, commit_nid, 16'h0000};
        if (cfg_addr == EA_STAT)   cfg_rdata = {31'h0, !busy_w};
        for (int q = 0; q < NUM_Q; q++) cfg_rdata = cfg_rdata | qrd[q];
    end

endmodule

// File: rtl/tqm_chk.sv
`timescale 1ns/1ps
module tqm_chk #(
    parameter int NUM_Q = 8,
    localparam int QW   = $clog2(NUM_Q)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  eng_start,
    input logic                  eng_done,
    input logic [2:0]            eng_qid,
    input logic                  busy,
    input logic [NUM_Q-1:0]      pend,
    input logic [NUM_Q-1:0][7:0] sprio
);
    logic [NUM_Q-1:0]      pend_q;
    logic [NUM_Q-1:0][7:0] prio_q;
    logic                  busy_q;
    logic                  beaten;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            prio_q <= '0;
            busy_q <= 1'b0;
        end else begin
            pend_q <= pend;
            prio_q <= sprio;
            busy_q <= busy;
        end
    end

    always_comb begin
        beaten = 1'b0;
        for (int q = 0; q < NUM_Q; q++) begin
            if (pend_q[q] && ((prio_q[q] > prio_q[QW'(eng_qid)]) ||
                ((prio_q[q] == prio_q[QW'(eng_qid)]) && (q < int'(eng_qid)))))
                beaten = 1'b1;
        end
    end

    p_start_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    p_start_from_idle_r10: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> !busy_q);

    p_busy_until_done_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !eng_done) |=> busy);

    p_no_queue_zero_r8: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> (eng_qid != 3'd0));

    p_from_pending_r9: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> pend_q[QW'(eng_qid)]);

    p_highest_first_r9: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> !beaten);

endmodule

bind task_queue_mgr tqm_chk #(.NUM_Q(NUM_Q)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .eng_qid   (eng_qid),
    .busy      (busy_w),
    .pend      (pend_w),
    .sprio     (sprio_w)
);

// File: tb/sim_task_queue_mgr.sv
`timescale 1ns/1ps
module sim_task_queue_mgr;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        eng_start;
    logic [2:0]  eng_qid;
    logic [31:0] eng_addr;
    logic [15:0] eng_td_size;
    logic [15:0] eng_td_count;
    logic        eng_done = 1'b0;

    int checks = 0;
    int fails  = 0;
    int starts = 0;
    int exp_starts = 0;
    bit finished = 0;
    logic [2:0]  l_qid;
    logic [31:0] l_addr;
    logic [15:0] l_size, l_count;

    always #4 clk = ~clk;

    task_queue_mgr u0 (
        .clk, .rst, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
        .eng_start, .eng_qid, .eng_addr, .eng_td_size, .eng_td_count, .eng_done
    );

    always @(negedge clk) begin
        if (!rst && eng_start) begin
            starts = starts + 1;
            l_qid   = eng_qid;
            l_addr  = eng_addr;
            l_size  = eng_td_size;
            l_count = eng_td_count;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    function automatic logic [15:0] qa(input int q, input int off);
        return 16'(32'h1000 + q * 32'h148 + off);
    endfunction

    function automatic logic [31:0] bar_pat(input int q, input int b);
        return 32'h5A00_0000 ^ (q << 20) ^ (b << 8) ^ (b * 7 + q);
    endfunction

    function automatic logic [31:0] d_addr(input int q, input int tag);
        return 32'h2000_0000 | (q << 8) | tag;
    endfunction

    function automatic logic [31:0] d_info(input int q, input int tag);
        return ((q + 1) << 16) | (tag + q + 1);
    endfunction

    task automatic push(input int q, input int prio, input int tag);
        wr(16'h0000, d_addr(q, tag));
        wr(16'h0004, d_info(q, tag));
        wr(16'h0008, 32'((q << 8) | prio));
    endtask

    task automatic done_pulse();
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
    endtask

    task automatic expect_dispatch(input int q, input int tag, input string req);
        logic [31:0] v;
        repeat (30) begin
            if (starts != exp_starts) break;
            @(negedge clk); #2;
        end
        exp_starts++;
        chk(req, 32'(starts), 32'(exp_starts));
        chk(req, 32'(l_qid), 32'(q));
        chk("R6", l_addr, d_addr(q, tag));
        chk("R6", 32'(l_size), d_info(q, tag) >> 16);
        chk("R6", 32'(l_count), d_info(q, tag) & 32'hFFFF);
        rd(16'h0010, v);
        chk("R11", (v >> 16) & 32'hFF, 32'(8'h40 + q));
        rd(16'h0014, v);
        chk("R10", v & 1, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(16'h0014, v); chk("R1", v & 1, 32'd1);
        rd(16'h0010, v); chk("R1", v, 32'd0);
        rd(16'h000C, v); chk("R1", v, 32'h3000);
        for (int q = 0; q < 8; q++) begin
            rd(qa(q, 'h04), v);
            chk("R1", v, (q < 6) ? 32'(q + 1) : 32'(q + 24));
        end

        // R2: plain bank words at stride 0x148
        for (int q = 0; q < 8; q++) begin
            wr(qa(q, 'h00), 32'(q & 1));
            wr(qa(q, 'h04), 32'h100 + q);
            wr(qa(q, 'h08), 32'hF00D_0000 + q);
            wr(qa(q, 'h0C), 32'hABCD_0000 | (q * 32'h111));
        end
        for (int q = 0; q < 8; q++) begin
            rd(qa(q, 'h00), v); chk("R2", v, 32'(q & 1));
            rd(qa(q, 'h04), v); chk("R2", v, 32'h100 + q);
            rd(qa(q, 'h08), v); chk("R2", v, 32'hF00D_0000 + q);
            rd(qa(q, 'h0C), v); chk("R2", v, (q * 32'h111) & 32'hFFFF);
        end

        // R3 / R4: masked fields
        wr(qa(4, 'h18), 32'hFFFF_FFFF);
        rd(qa(4, 'h18), v); chk("R3", v, 32'h01FF_0000);
        wr(qa(5, 'h18), 32'h40 << 14);
        rd(qa(5, 'h18), v); chk("R3", v, (32'h40 << 14) & 32'h01FF_0000);
        wr(qa(2, 'h10), 32'hFFFF_FFFF);
        rd(qa(2, 'h10), v); chk("R4", v, 32'h0000_FF01);

        // R5: full base-address sweep
        for (int q = 0; q < 8; q++)
            for (int b = 0; b < 32; b++)
                wr(qa(q, 'h40 + 4 * b), bar_pat(q, b));
        for (int q = 0; q < 8; q++)
            for (int b = 0; b < 32; b++) begin
                rd(qa(q, 'h40 + 4 * b), v);
                chk("R5", v, bar_pat(q, b));
            end

        // node ids for the dispatch tests
        for (int q = 0; q < 8; q++)
            wr(qa(q, 'h10), 32'(((8'h40 + q) << 8) | 1));

        // R6 / R10 / R9 / R12: one running, six pushed while busy
        push(1, 4, 0);
        expect_dispatch(1, 0, "R6");
        push(3, 3, 0);
        push(5, 5, 0);
        push(7, 8'h1F, 0);
        push(2, 9, 0);
        push(4, 9, 0);
        push(6, 2, 1);
        push(6, 2, 2);
        repeat (5) @(negedge clk);
        #2 chk("R10", 32'(starts), 32'(exp_starts));
        rd(16'h0014, v); chk("R10", v & 1, 32'd0);
        done_pulse();
        expect_dispatch(7, 0, "R9");
        done_pulse();
        expect_dispatch(2, 0, "R9");
        done_pulse();
        expect_dispatch(4, 0, "R9");
        done_pulse();
        expect_dispatch(5, 0, "R9");
        done_pulse();
        expect_dispatch(3, 0, "R9");
        done_pulse();
        expect_dispatch(6, 2, "R12");
        done_pulse();
        repeat (3) @(negedge clk);
        #2 chk("R10", 32'(starts), 32'(exp_starts));
        rd(16'h0014, v); chk("R10", v & 1, 32'd1);

        // R7: zero info word
        wr(16'h0004, 32'd0);
        wr(16'h0008, 32'h0000_0305);
        repeat (4) @(negedge clk);
        #2 chk("R7", 32'(starts), 32'(exp_starts));
        rd(16'h0014, v); chk("R7", v & 1, 32'd1);

        // R8: queue id 0
        wr(16'h0004, 32'h0001_0001);
        wr(16'h0008, 32'h0000_0007);
        repeat (4) @(negedge clk);
        #2 chk("R8", 32'(starts), 32'(exp_starts));
        rd(16'h0014, v); chk("R8", v & 1, 32'd1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule